// File: doc/BRIEF.md
# Multi-Cycle Five-Step RISC Core

This block is a small processor that does not overlap instructions. It runs fixed 32-bit register-register instructions, one at a time. Each instruction takes five clock cycles in a fixed order:

1. Fetch the instruction word.
2. Decode it and read the two source registers.
3. Execute, or form the data address or jump target.
4. Access data memory, or decide the next PC.
5. Write the result back.

Every instruction goes through all five steps, even when a step has no work for it.

Instruction memory is read combinationally at `imem_addr`. Data memory is also read combinationally at `dmem_addr`, and a write happens on the clock edge that ends a cycle with `dmem_we` high.

The register file holds 32 registers of 32 bits. There is also a separate one-bit condition flag. Only the compare instruction writes that flag, and only the jump-if-clear instruction reads it.

Instruction fields:
- opcode: bits [31:26]
- first source: bits [25:21]
- second source: bits [20:16]
- destination, register formats: bits [15:11]
- destination, immediate formats: bits [20:16]
- 16-bit immediate: bits [15:0]

Top module: `mc5_core`

## Requirements
- R1: Every instruction occupies exactly five cycles. The fetch address stays constant until the fourth cycle of the instruction ends. After that it holds the next PC: the fetch address + 4 for anything that is not a taken jump.
- R2: Register-register opcodes write `rs op rt` to the register at [15:11]. The opcodes are 0x01 add, 0x02 subtract (rs - rt), 0x03 and, 0x04 or, 0x05 xor, and 0x06 set-if-less-than. Set-if-less-than is a signed test and gives 1 or 0.
- R3: Immediate opcodes write `rs op sext(imm16)` to the register at [20:16]. The opcodes are 0x08 add, 0x0C and, 0x0D or, and 0x0E xor. Bit 15 of the immediate fills the upper half for all four.
- R4: Load (0x10) writes the data word at `rs + sext(imm16)` to the register at [20:16]. Negative displacements are included.
- R5: Store (0x11) writes `rt` to address `rs + sext(imm16)`. `dmem_we` is high for exactly one cycle per store: the fourth cycle of the instruction. It is never high for any other opcode.
- R6: Compare (0x18) sets the flag to 1 when `rs > rt` (signed) is false, and to 0 when it is true. It writes no general register, whatever its [15:11] field holds.
- R7: Jump (0x20) sets PC to `PC + 4 + 4*sext(imm16)`.
- R8: Jump-if-clear (0x21) goes to the same target as R7 when the flag is 0. When the flag is 1 it goes to `PC + 4`.
- R9: Register 0 always reads as zero. Writes to it are discarded.
- R10: Any opcode not listed above, including 0x00 and 0x3F, changes no register, no flag and no memory. It still takes five cycles and advances PC by 4.
- R11: While `rst_n` is low, `dmem_we` is 0 and `imem_addr` is 0. The flag is 0 after reset. The first fetch happens on the third rising edge after `rst_n` rises, because reset release passes through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| imem_addr | output | 32 | Byte address of the instruction being fetched (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address for load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, one cycle |
| dmem_rdata | input | 32 | Data word at `dmem_addr` |

## Verification
A step counter that slips shows up as a change of `imem_addr` or a `dmem_we` pulse in the wrong cycle of the five. The bench samples both cycle by cycle. A wrong operand, wrong immediate extension or corrupted register shows up only at the next store, so every program ends by storing its result within a few instructions. A flag written by the wrong instruction, or read with the wrong polarity, appears as a skipped or executed write in the jump tests. That becomes visible on the stores about ten cycles later.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam logic [5:0] OPC_ADD  = 6'h01;
  localparam logic [5:0] OPC_SUB  = 6'h02;
  localparam logic [5:0] OPC_AND  = 6'h03;
  localparam logic [5:0] OPC_OR   = 6'h04;
  localparam logic [5:0] OPC_XOR  = 6'h05;
  localparam logic [5:0] OPC_SLT  = 6'h06;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_ANDI = 6'h0C;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] OPC_XORI = 6'h0E;
  localparam logic [5:0] OPC_LW   = 6'h10;
  localparam logic [5:0] OPC_SW   = 6'h11;
  localparam logic [5:0] OPC_CMP  = 6'h18;
  localparam logic [5:0] OPC_JMP  = 6'h20;
  localparam logic [5:0] OPC_JNZ  = 6'h21;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_MEMORY = 3'd3,
    ST_WRITE  = 3'd4
  } step_e;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_XOR = 3'd4,
    ALU_SLT = 3'd5
  } alu_op_e;

  typedef struct packed {
    alu_op_e alu_op;
    logic    use_imm;
    logic    rd_imm;
    logic    reg_write;
    logic    mem_read;
    logic    mem_write;
    logic    is_cmp;
    logic    is_jump;
    logic    is_cond;
  } ctrl_t;

endpackage

// File: rtl/core_step_seq.sv
module core_step_seq
  import core_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output step_e step
);

  step_e step_q;
  step_e step_d;

  always_comb begin
    unique case (step_q)
      ST_FETCH:  step_d = ST_DECODE;
      ST_DECODE: step_d = ST_EXEC;
      ST_EXEC:   step_d = ST_MEMORY;
      ST_MEMORY: step_d = ST_WRITE;
      default:   step_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= ST_FETCH;
    else        step_q <= step_d;
  end

  assign step = step_q;

endmodule

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.alu_op = ALU_ADD;
    unique case (opcode)
      OPC_ADD:  begin ctrl.alu_op = ALU_ADD; ctrl.reg_write = 1'b1; end
      OPC_SUB:  begin ctrl.alu_op = ALU_SUB; ctrl.reg_write = 1'b1; end
      OPC_AND:  begin ctrl.alu_op = ALU_AND; ctrl.reg_write = 1'b1; end
      OPC_OR:   begin ctrl.alu_op = ALU_OR;  ctrl.reg_write = 1'b1; end
      OPC_XOR:  begin ctrl.alu_op = ALU_XOR; ctrl.reg_write = 1'b1; end
      OPC_SLT:  begin ctrl.alu_op = ALU_SLT; ctrl.reg_write = 1'b1; end
      OPC_ADDI: begin
        ctrl.alu_op = ALU_ADD; ctrl.use_imm = 1'b1;
        ctrl.rd_imm = 1'b1;    ctrl.reg_write = 1'b1;
      end
      OPC_ANDI: begin
        ctrl.alu_op = ALU_AND; ctrl.use_imm = 1'b1;
        ctrl.rd_imm = 1'b1;    ctrl.reg_write = 1'b1;
      end
      OPC_ORI: begin
        ctrl.alu_op = ALU_OR; ctrl.use_imm = 1'b1;
        ctrl.rd_imm = 1'b1;   ctrl.reg_write = 1'b1;
      end
      OPC_XORI: begin
        ctrl.alu_op = ALU_XOR; ctrl.use_imm = 1'b1;
        ctrl.rd_imm = 1'b1;    ctrl.reg_write = 1'b1;
      end
      OPC_LW: begin
        ctrl.use_imm = 1'b1;   ctrl.rd_imm = 1'b1;
        ctrl.reg_write = 1'b1; ctrl.mem_read = 1'b1;
      end
      OPC_SW: begin
        ctrl.use_imm = 1'b1; ctrl.mem_write = 1'b1;
      end
      OPC_CMP: ctrl.is_cmp = 1'b1;
      OPC_JMP: ctrl.is_jump = 1'b1;
      OPC_JNZ: begin ctrl.is_jump = 1'b1; ctrl.is_cond = 1'b1; end
      default: ctrl.alu_op = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y,
  output logic            a_gt_b
);

  logic a_lt_b;

  assign a_lt_b = $signed(a) < $signed(b);
  assign a_gt_b = $signed(a) > $signed(b);

  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, a_lt_b};
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic [AW-1:0]   ra1,
  input  logic [AW-1:0]   ra2,
  output logic [XLEN-1:0] rd1,
  output logic [XLEN-1:0] rd2,
  input  logic            we,
  input  logic [AW-1:0]   wa,
  input  logic [XLEN-1:0] wd
);

  logic [XLEN-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_store
      logic wr_en;
      assign wr_en = we && (wa == AW'(g));
      always_ff @(posedge clk) begin
        if (wr_en) regs[g] <= wd;
      end
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];

endmodule

// File: rtl/mc5_core.sv
module mc5_core
  import core_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int NREG  = 32,
  parameter int IMM_W = 16,
  localparam int RIDX_W = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_rdata,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  output logic            dmem_we,
  input  logic [XLEN-1:0] dmem_rdata
);

  localparam int OPC_LSB = 26;
  localparam int RS_MSB  = 25;
  localparam int RT_MSB  = 20;
  localparam int RD_MSB  = 15;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // step sequencer
  step_e step;
  core_step_seq u_seq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .step  (step)
  );

  logic en_fetch, en_decode, en_exec, en_memory, en_write;
  assign en_fetch  = (step == ST_FETCH);
  assign en_decode = (step == ST_DECODE);
  assign en_exec   = (step == ST_EXEC);
  assign en_memory = (step == ST_MEMORY);
  assign en_write  = (step == ST_WRITE);

  // architectural and inter-step state
  logic [XLEN-1:0]   pc_q, npc_q;
  logic [31:0]       ir_q;
  logic [XLEN-1:0]   a_q, b_q, imm_q;
  logic [XLEN-1:0]   alu_q, res_q;
  logic [RIDX_W-1:0] dest_q;
  ctrl_t             ctrl_q;
  logic              flag_q;

  // decode of the held instruction
  ctrl_t             ctrl_dec;
  logic [RIDX_W-1:0] rs_idx, rt_idx, rd_idx;
  logic [XLEN-1:0]   imm_ext;
  logic [XLEN-1:0]   rf_rd1, rf_rd2;

  core_decode u_dec (
    .opcode (ir_q[31:OPC_LSB]),
    .ctrl   (ctrl_dec)
  );

  assign rs_idx  = ir_q[RS_MSB -: RIDX_W];
  assign rt_idx  = ir_q[RT_MSB -: RIDX_W];
  assign rd_idx  = ctrl_dec.rd_imm ? ir_q[RT_MSB -: RIDX_W] : ir_q[RD_MSB -: RIDX_W];
  assign imm_ext = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};

  // register file
  logic rf_we;
  assign rf_we = en_write && ctrl_q.reg_write;

  core_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk (clk),
    .ra1 (rs_idx),
    .ra2 (rt_idx),
    .rd1 (rf_rd1),
    .rd2 (rf_rd2),
    .we  (rf_we),
    .wa  (dest_q),
    .wd  (res_q)
  );

  // execute operands and ALU
  logic [XLEN-1:0] jump_off, op_a, op_b, alu_y;
  logic            alu_gt;

  assign jump_off = {imm_q[XLEN-3:0], 2'b00};
  assign op_a     = ctrl_q.is_jump ? npc_q : a_q;
  assign op_b     = ctrl_q.is_jump ? jump_off : (ctrl_q.use_imm ? imm_q : b_q);

  core_alu #(.XLEN(XLEN)) u_alu (
    .op     (ctrl_q.alu_op),
    .a      (op_a),
    .b      (op_b),
    .y      (alu_y),
    .a_gt_b (alu_gt)
  );

  // next-state values
  logic            take_jump;
  logic [XLEN-1:0] pc_d, res_d;
  logic            flag_d;
  logic            flag_en;

  assign take_jump = ctrl_q.is_jump && (!ctrl_q.is_cond || !flag_q);
  assign pc_d      = take_jump ? alu_q : npc_q;
  assign res_d     = ctrl_q.mem_read ? dmem_rdata : alu_q;
  assign flag_d    = !alu_gt;
  assign flag_en   = en_exec && ctrl_q.is_cmp;

  // control registers (reset)
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      pc_q   <= '0;
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (en_memory) pc_q   <= pc_d;
      if (en_decode) ctrl_q <= ctrl_dec;
      if (flag_en)   flag_q <= flag_d;
    end
  end

  // datapath registers (no reset)
  always_ff @(posedge clk) begin
    if (en_fetch) begin
      ir_q  <= imem_rdata;
      npc_q <= pc_q + XLEN'(4);
    end
    if (en_decode) begin
      a_q    <= rf_rd1;
      b_q    <= rf_rd2;
      imm_q  <= imm_ext;
      dest_q <= rd_idx;
    end
    if (en_exec)   alu_q <= alu_y;
    if (en_memory) res_q <= res_d;
  end

  // memory ports
  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_q;
  assign dmem_wdata = b_q;
  assign dmem_we    = en_memory && ctrl_q.mem_write;

  // signals brought out for the bound checker
  logic cmp_in_exec;
  logic write_step;
  assign cmp_in_exec = en_exec && ctrl_q.is_cmp;
  assign write_step  = en_write;

endmodule

// File: rtl/mc5_core_chk.sv
module mc5_core_chk
  import core_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input step_e             step,
  input logic [XLEN-1:0]   pc,
  input logic              dmem_we,
  input logic              flag,
  input logic              cmp_in_exec,
  input logic [RIDX_W-1:0] rs_idx,
  input logic [XLEN-1:0]   a_val
);

  AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> !dmem_we); // R5

  AST_STORE_IN_MEM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> step == ST_MEMORY); // R5

  AST_PC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (step != ST_MEMORY) |=> $stable(pc)); // R1

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    pc[1:0] == 2'b00); // R7

  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_WRITE) |=> (step == ST_FETCH)); // R1

  AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (step == ST_DECODE && rs_idx == '0) |=> (a_val == '0)); // R9

  AST_FLAG_ONLY_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_in_exec |=> $stable(flag)); // R6

endmodule

bind mc5_core mc5_core_chk #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .step        (step),
  .pc          (pc_q),
  .dmem_we     (dmem_we),
  .flag        (flag_q),
  .cmp_in_exec (cmp_in_exec),
  .rs_idx      (rs_idx),
  .a_val       (a_q)
);

// File: tb/tb_mc5_core.sv
module tb_mc5_core;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 50000;

  localparam logic [5:0] T_ADD = 6'h01, T_SUB = 6'h02, T_AND = 6'h03, T_OR = 6'h04;
  localparam logic [5:0] T_XOR = 6'h05, T_SLT = 6'h06, T_ADDI = 6'h08, T_ANDI = 6'h0C;
  localparam logic [5:0] T_ORI = 6'h0D, T_XORI = 6'h0E, T_LW = 6'h10, T_SW = 6'h11;
  localparam logic [5:0] T_CMP = 6'h18, T_JMP = 6'h20, T_JNZ = 6'h21;
  localparam logic [31:0] NOP_WORD = 32'hFC00_0000;

  // {opcode, immediate form, operand a, operand b or imm16, expected}
  localparam int NVEC = 13;
  localparam logic [102:0] VECS [NVEC] = '{
    {T_ADD,  1'b0, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C},
    {T_ADD,  1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
    {T_SUB,  1'b0, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE},
    {T_AND,  1'b0, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 32'h00F0_00F0},
    {T_OR,   1'b0, 32'hF000_0000, 32'h0000_000F, 32'hF000_000F},
    {T_XOR,  1'b0, 32'hAAAA_AAAA, 32'hFFFF_0000, 32'h5555_AAAA},
    {T_SLT,  1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001},
    {T_SLT,  1'b0, 32'h0000_0005, 32'h0000_0002, 32'h0000_0000},
    {T_ADDI, 1'b1, 32'h0000_000A, 32'h0000_FFFF, 32'h0000_0009},
    {T_ADDI, 1'b1, 32'h7FFF_0000, 32'h0000_8000, 32'h7FFE_8000},
    {T_ANDI, 1'b1, 32'h1234_5678, 32'h0000_00FF, 32'h0000_0078},
    {T_ORI,  1'b1, 32'h1000_0000, 32'h0000_8001, 32'hFFFF_8001},
    {T_XORI, 1'b1, 32'h0000_FFFF, 32'h0000_00F0, 32'h0000_FF0F}
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] imem_addr, imem_rdata;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int nchk = 0;
  int nerr = 0;
  int st_cnt = 0;

  mc5_core dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_we    (dmem_we),
    .dmem_rdata (dmem_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (dmem_we) begin
      dmem[dmem_addr[7:2]] <= dmem_wdata;
      st_cnt <= st_cnt + 1;
    end
  end

  function automatic logic [31:0] enc_r(logic [5:0] op, int rd, int rs, int rt);
    return {op, 5'(rs), 5'(rt), 5'(rd), 11'd0};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rt, int rs, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin
      imem[i] = NOP_WORD;
      dmem[i] = 32'h0;
    end
  endtask

  // leaves the bench at the falling edge before the first fetch edge
  task automatic start();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    nerr++;
    nchk++;
    $display("FAIL R1 watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int base;
    rst_n = 1'b0;
    clear_mem();

    // R11: outputs while reset is held
    repeat (3) @(negedge clk);
    chk("R11 dmem_we in reset", {31'd0, dmem_we}, 32'd0);
    chk("R11 imem_addr in reset", imem_addr, 32'd0);

    // R2 / R3: table of ALU vectors
    for (int v = 0; v < NVEC; v++) begin
      logic [5:0]  op;
      logic        isimm;
      logic [31:0] va, vb, ve;
      {op, isimm, va, vb, ve} = VECS[v];
      rst_n = 1'b0;
      clear_mem();
      dmem[0] = va;
      dmem[1] = vb;
      imem[0] = enc_i(T_LW, 1, 0, 16'd0);
      imem[1] = enc_i(T_LW, 2, 0, 16'd4);
      imem[2] = isimm ? enc_i(op, 3, 1, vb[15:0]) : enc_r(op, 3, 1, 2);
      imem[3] = enc_i(T_SW, 3, 0, 16'd8);
      imem[4] = enc_i(T_JMP, 0, 0, 16'hFFFF);
      start();
      base = st_cnt;
      run(35);
      chk(isimm ? "R3 imm result" : "R2 reg result", dmem[2], ve);
      chk("R5 one store per vector", 32'(st_cnt - base), 32'd1);
    end

    // R1 / R10: unknown opcodes advance PC by 4 every five cycles
    clear_mem();
    imem[1] = 32'h0000_0000;
    start();
    base = st_cnt;
    run(3);  chk("R1 pc held in cycle 4", imem_addr, 32'd0);
    run(1);  chk("R1 pc after first instr", imem_addr, 32'd4);
    run(4);  chk("R1 pc held second instr", imem_addr, 32'd4);
    run(1);  chk("R10 opcode 00 advances pc", imem_addr, 32'd8);
    run(10); chk("R10 no store from unknown ops", 32'(st_cnt - base), 32'd0);

    // R5 / R9: store strobe timing, register 0 stays zero
    clear_mem();
    dmem[3] = 32'hDEAD_0000;
    dmem[4] = 32'h0000_BEEF;
    imem[0] = enc_i(T_SW, 0, 0, 16'd12);
    imem[1] = enc_i(T_ADDI, 0, 0, 16'h0055);
    imem[2] = enc_i(T_SW, 0, 0, 16'd16);
    imem[3] = enc_i(T_JMP, 0, 0, 16'hFFFF);
    start();
    run(2); chk("R5 no strobe in cycle 3", {31'd0, dmem_we}, 32'd0);
    run(1); chk("R5 strobe in cycle 4", {31'd0, dmem_we}, 32'd1);
            chk("R5 store address", dmem_addr, 32'd12);
    run(1); chk("R5 strobe drops", {31'd0, dmem_we}, 32'd0);
    chk("R9 r0 stored as zero", dmem[3], 32'd0);
    run(15);
    chk("R9 write to r0 discarded", dmem[4], 32'd0);

    // R7: forward and backward jumps
    clear_mem();
    imem[0] = enc_i(T_JMP, 0, 0, 16'd2);
    imem[3] = enc_i(T_JMP, 0, 0, 16'hFFFC);
    start();
    run(4); chk("R7 forward jump target", imem_addr, 32'd12);
    run(5); chk("R7 backward jump target", imem_addr, 32'd0);

    // R11 / R6 / R8: flag after reset, compare polarity, conditional jump
    clear_mem();
    dmem[0] = 32'd5;
    dmem[1] = 32'd3;
    dmem[5] = 32'h0000_0099;
    imem[0]  = enc_i(T_JNZ, 0, 0, 16'd1);
    imem[1]  = enc_i(T_SW, 0, 0, 16'd40);
    imem[2]  = enc_i(T_LW, 1, 0, 16'd0);
    imem[3]  = enc_i(T_LW, 2, 0, 16'd4);
    imem[4]  = enc_i(T_ADDI, 4, 0, 16'd7);
    imem[5]  = enc_i(T_ADDI, 6, 0, 16'h0033);
    imem[6]  = enc_r(T_CMP, 6, 1, 2);
    imem[7]  = enc_i(T_JNZ, 0, 0, 16'd1);
    imem[8]  = enc_i(T_ADDI, 4, 0, 16'd1);
    imem[9]  = enc_r(T_CMP, 6, 2, 1);
    imem[10] = enc_i(T_JNZ, 0, 0, 16'd1);
    imem[11] = enc_i(T_ADDI, 5, 0, 16'd2);
    imem[12] = enc_i(T_SW, 4, 0, 16'd16);
    imem[13] = enc_i(T_SW, 5, 0, 16'd20);
    imem[14] = enc_i(T_SW, 6, 0, 16'd24);
    imem[15] = enc_i(T_JMP, 0, 0, 16'hFFFF);
    start();
    run(4); chk("R11 flag clear after reset, jump taken", imem_addr, 32'd8);
    run(96);
    chk("R8 taken when flag clear skips write", dmem[4], 32'd7);
    chk("R6 R8 false compare sets flag, falls through", dmem[5], 32'd2);
    chk("R6 compare writes no register", dmem[6], 32'h0000_0033);

    // R4: load with negative displacement
    clear_mem();
    dmem[6] = 32'h1357_9BDF;
    imem[0] = enc_i(T_ADDI, 1, 0, 16'h0020);
    imem[1] = enc_i(T_LW, 2, 1, 16'hFFF8);
    imem[2] = enc_i(T_SW, 2, 0, 16'd28);
    imem[3] = enc_i(T_JMP, 0, 0, 16'hFFFF);
    start();
    run(30);
    chk("R4 load negative displacement", dmem[7], 32'h1357_9BDF);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule